// File: doc/BRIEF.md
# Keyed-restart watchdog timer

This block is a watchdog countdown timer behind a simple 32-bit word-addressed register bus. Software programs a reload value and a control word. When enabled, a counter counts down from the reload value, one step per tick. A tick is either every peripheral clock or one microsecond from an internal prescaler. Software keeps the system alive by writing a 16-bit key to a restart register, which reloads the counter. Any other value written there is discarded.

If the counter reaches zero, the block performs its timeout action and halts. The action can be a system reset pulse, an external reset pulse and a sticky interrupt flag. The pulse width is programmable, and the output polarity and drive type can only be changed by writing fixed key codes in the top byte of the configuration register. A memory-controller reset-hold input vetoes the timeout: while it is high, expiry takes no action and wipes the control register instead.

Top module: `watchdog_top`

## Requirements
- R1: After reset the counter and reload registers read 0x03EF1480, control reads 0, the configuration register reads 0x000000FF, `irq` is 0 and both reset outputs sit at their inactive level (high, since polarity bit 31 is 0).
- R2: Register word offsets: 0x00 counter (read-only, writes ignored), 0x04 reload, 0x08 restart (reads 0), 0x0C control, 0x18 reset configuration, 0x1C mask (plain read/write). Other offsets read 0 and ignore writes. An access whose address bits [1:0] are not zero is ignored and reads 0.
- R3: Control bits: 0 enable, 1 system reset on timeout, 2 interrupt on timeout, 3 external reset on timeout, 4 microsecond tick select, 5 full-chip mode (driven on `rst_full_chip`). Bits 11:8 are always stored as zero; all other bits keep what was written.
- R4: A restart write whose low 16 bits equal 0x4755 loads the counter from the reload register, restarts the prescaler phase and clears `irq`. Any other value has no effect.
- R5: A control write that changes enable from 0 to 1 loads the counter from reload. A write from 1 to 0 freezes the counter. A write that keeps enable unchanged only updates the stored bits.
- R6: With control bit 4 clear, the counter steps on every clock. With it set, the counter steps once per TICK_DIV clocks, the first step coming TICK_DIV clocks after a reload.
- R7: The counter saturates at zero. Expiry happens on the tick where the counter goes from 1 to 0 (or on the first tick if it is already 0). After expiry the counter stays at 0 until the next reload.
- R8: A reload (key restart or enable rise) in the cycle where expiry would occur wins: the counter takes the reload value and no timeout action happens.
- R9: Configuration bits 19:0 hold the pulse width and take every written value. A written top byte of 0xA5 sets bit 31 (active-high outputs), 0x5A clears it, 0xA8 sets bit 30 (push-pull, driven on `rst_push_pull`), 0x8A clears it. Any other top byte leaves bits 31:30 unchanged. Bits 29:20 read 0.
- R10: On expiry with `mc_hold` low, `rst_out` is asserted if control bit 1 is set, and `ext_rst_out` if control bit 3 is set. Each is asserted for exactly width ticks, starting in the expiry cycle; a width of 0 gives no pulse. The asserted level is 1 when bit 31 is set, otherwise 0.
- R11: On expiry with `mc_hold` low and control bit 2 set, `irq` goes to 1 and stays there until a key restart.
- R12: On expiry with `mc_hold` high, no pulse is driven, `irq` is not set, and the whole control register becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| mc_hold | input | 1 | Memory-controller reset hold; vetoes the timeout action |
| irq | output | 1 | Sticky timeout interrupt flag |
| rst_out | output | 1 | System reset pulse, polarity per configuration bit 31 |
| ext_rst_out | output | 1 | External reset pulse, polarity per configuration bit 31 |
| rst_push_pull | output | 1 | Drive-type selection for the reset pads (configuration bit 30) |
| rst_full_chip | output | 1 | Reset scope selection (control bit 5) |

## Verification
The bench aims at the keys. A restart value that is one off the key, or has the key only in the upper half, must leave the count running; a design that compares all 32 bits, or any bits, either ignores good restarts or accepts bad ones. It toggles enable mid-count and rewrites control without changing enable. A design that reloads on every control write would show a jump in the counter, and one that does not freeze would keep counting. Expiry is checked with `mc_hold` both high and low, and with a restart landing on the expiry cycle: a wrong priority leaks a reset pulse or sets the interrupt, and a hold that only suppresses the pulse leaves control non-zero. Keyed top bytes, including an unknown code, are walked through the configuration register, and the microsecond tick is timed to the exact cycle of its first step.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned WIDTH_BITS = 20;

    localparam logic [DW-1:0] CNT_INIT = 32'h03EF_1480;
    localparam logic [DW-1:0] CFG_INIT = 32'h0000_00FF;
    localparam logic [15:0]   RESTART_KEY = 16'h4755;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    // word index of each register (byte offset / 4)
    typedef enum logic [2:0] {
        IDX_COUNT   = 3'd0,
        IDX_RELOAD  = 3'd1,
        IDX_RESTART = 3'd2,
        IDX_CTRL    = 3'd3,
        IDX_CFG     = 3'd6,
        IDX_MASK    = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [25:0] upper;
        logic        full_chip;
        logic        tick_us;
        logic        ext_en;
        logic        irq_en;
        logic        sys_en;
        logic        en;
    } ctrl_t;

    typedef struct packed {
        logic                  act_high;
        logic                  push_pull;
        logic [9:0]            zero;
        logic [WIDTH_BITS-1:0] width;
    } cfg_t;

    function automatic ctrl_t ctrl_clean(input logic [DW-1:0] d);
        return ctrl_t'(d & ~32'h0000_0F00);
    endfunction

    function automatic cfg_t cfg_update(input cfg_t cur, input logic [DW-1:0] d);
        cfg_t nxt;
        nxt = cur;
        nxt.zero = '0;
        nxt.width = d[WIDTH_BITS-1:0];
        case (d[31:24])
            KEY_POL_HIGH: nxt.act_high = 1'b1;
            KEY_POL_LOW:  nxt.act_high = 1'b0;
            KEY_DRV_PP:   nxt.push_pull = 1'b1;
            KEY_DRV_OD:   nxt.push_pull = 1'b0;
            default: ;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic [DW-1:0]         cnt_i,
    input  logic                  expire_i,
    input  logic                  hold_i,
    output logic [DW-1:0]         reload_o,
    output logic                  load_o,
    output logic                  en_o,
    output logic                  sys_en_o,
    output logic                  ext_en_o,
    output logic                  tick_us_o,
    output logic                  full_chip_o,
    output logic [WIDTH_BITS-1:0] width_o,
    output logic                  act_high_o,
    output logic                  push_pull_o,
    output logic                  irq_o
);
    localparam int IW = ADDR_W - 2;

    logic [IW-1:0] idx;
    logic          aligned;
    logic          wr_ok;
    logic [DW-1:0] reload_q;
    logic [DW-1:0] mask_q;
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_new;
    cfg_t          cfg_q;
    logic          irq_q;
    logic          key_restart;
    logic          wr_ctrl;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_ok   = sel & wr & aligned;

    assign wr_ctrl     = wr_ok && (idx == IW'(IDX_CTRL));
    assign key_restart = wr_ok && (idx == IW'(IDX_RESTART)) && (wdata[15:0] == RESTART_KEY);
    assign ctrl_new    = ctrl_clean(wdata);
    assign load_o      = key_restart | (wr_ctrl & ctrl_new.en & ~ctrl_q.en);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= CNT_INIT;
            mask_q   <= '0;
            ctrl_q   <= '0;
            cfg_q    <= cfg_t'(CFG_INIT);
            irq_q    <= 1'b0;
        end else begin
            if (wr_ok && idx == IW'(IDX_RELOAD)) reload_q <= wdata;
            if (wr_ok && idx == IW'(IDX_MASK))   mask_q   <= wdata;
            if (wr_ok && idx == IW'(IDX_CFG))    cfg_q    <= cfg_update(cfg_q, wdata);
            if (expire_i && hold_i)              ctrl_q   <= '0;
            else if (wr_ctrl)                    ctrl_q   <= ctrl_new;
            if (key_restart)                     irq_q    <= 1'b0;
            else if (expire_i && !hold_i && ctrl_q.irq_en) irq_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (idx == IW'(IDX_COUNT))       rdata = cnt_i;
            else if (idx == IW'(IDX_RELOAD)) rdata = reload_q;
            else if (idx == IW'(IDX_CTRL))   rdata = ctrl_q;
            else if (idx == IW'(IDX_CFG))    rdata = cfg_q;
            else if (idx == IW'(IDX_MASK))   rdata = mask_q;
        end
    end

    assign reload_o    = reload_q;
    assign en_o        = ctrl_q.en;
    assign sys_en_o    = ctrl_q.sys_en;
    assign ext_en_o    = ctrl_q.ext_en;
    assign tick_us_o   = ctrl_q.tick_us;
    assign full_chip_o = ctrl_q.full_chip;
    assign width_o     = cfg_q.width;
    assign act_high_o  = cfg_q.act_high;
    assign push_pull_o = cfg_q.push_pull;
    assign irq_o       = irq_q;

    // R12
    hold_wipes_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_i && hold_i) |=> (ctrl_q == '0));

    // R3
    ctrl_gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[11:8] == 4'h0);

    // R11
    irq_needs_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(expire_i && !hold_i));

endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
    parameter int TICK_DIV = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_us,
    input  logic sync_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;
    logic          us_pulse;

    assign us_pulse = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || sync_i || us_pulse) pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;
    end

    assign tick_o = sel_us ? us_pulse : 1'b1;

    // R6
    pre_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LAST);

endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_i,
    input  logic                  load_i,
    input  logic [DW-1:0]         reload_i,
    input  logic                  en_i,
    input  logic                  sys_en_i,
    input  logic                  ext_en_i,
    input  logic                  hold_i,
    input  logic [WIDTH_BITS-1:0] width_i,
    output logic [DW-1:0]         cnt_o,
    output logic                  expire_o,
    output logic                  sys_act_o,
    output logic                  ext_act_o
);
    logic [DW-1:0]         cnt_q;
    logic                  halted_q;
    logic                  run;
    logic [WIDTH_BITS-1:0] pulse_q;
    logic                  sys_q;
    logic                  ext_q;

    assign run      = en_i & ~halted_q;
    assign expire_o = tick_i & run & ~load_i & (cnt_q <= DW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= CNT_INIT;
            halted_q <= 1'b0;
        end else if (load_i) begin
            cnt_q    <= reload_i;
            halted_q <= 1'b0;
        end else begin
            if (tick_i && run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (expire_o) halted_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
            sys_q   <= 1'b0;
            ext_q   <= 1'b0;
        end else if (expire_o && !hold_i) begin
            pulse_q <= width_i;
            sys_q   <= sys_en_i;
            ext_q   <= ext_en_i;
        end else if (tick_i && pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

    assign cnt_o     = cnt_q;
    assign sys_act_o = (pulse_q != '0) & sys_q;
    assign ext_act_o = (pulse_q != '0) & ext_q;

    // R7
    never_climbs_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> cnt_q <= $past(cnt_q));

    // R5
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(cnt_q));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == $past(reload_i));

    // R12
    hold_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_o && hold_i && pulse_q == '0) |=> !(sys_act_o || ext_act_o));

endmodule

// File: rtl/watchdog_top.sv
module watchdog_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int TICK_DIV = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              mc_hold,
    output logic              irq,
    output logic              rst_out,
    output logic              ext_rst_out,
    output logic              rst_push_pull,
    output logic              rst_full_chip
);
    logic [DW-1:0]         cnt, reload;
    logic                  load, expire, tick;
    logic                  en, sys_en, ext_en, tick_us;
    logic [WIDTH_BITS-1:0] width;
    logic                  act_high, sys_act, ext_act;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .cnt_i(cnt), .expire_i(expire),
        .hold_i(mc_hold), .reload_o(reload), .load_o(load), .en_o(en),
        .sys_en_o(sys_en), .ext_en_o(ext_en), .tick_us_o(tick_us),
        .full_chip_o(rst_full_chip), .width_o(width), .act_high_o(act_high),
        .push_pull_o(rst_push_pull), .irq_o(irq)
    );

    wdt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .sel_us(tick_us), .sync_i(load), .tick_o(tick)
    );

    wdt_count u_count (
        .clk(clk), .rst(rst), .tick_i(tick), .load_i(load), .reload_i(reload),
        .en_i(en), .sys_en_i(sys_en), .ext_en_i(ext_en), .hold_i(mc_hold),
        .width_i(width), .cnt_o(cnt), .expire_o(expire),
        .sys_act_o(sys_act), .ext_act_o(ext_act)
    );

    assign rst_out     = act_high ? sys_act : ~sys_act;
    assign ext_rst_out = act_high ? ext_act : ~ext_act;

endmodule

// File: tb/test_watchdog_top.sv
module test_watchdog_top;
    localparam int CLK_NS   = 10;
    localparam int TICK_DIV = 24;
    localparam int NV       = 12;

    // {byte address, write data, expected readback}
    localparam logic [71:0] VEC [NV] = '{
        {8'h04, 32'h1234_5678, 32'h1234_5678},
        {8'h0C, 32'hFFFF_FFF0, 32'hFFFF_F0F0},
        {8'h00, 32'h0000_0055, 32'h03EF_1480},
        {8'h08, 32'h0000_1111, 32'h0000_0000},
        {8'h1C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h18, 32'h00AB_CDEF, 32'h000B_CDEF},
        {8'h18, 32'hA501_2345, 32'h8001_2345},
        {8'h18, 32'hA800_0010, 32'hC000_0010},
        {8'h18, 32'h5A00_0020, 32'h4000_0020},
        {8'h18, 32'h8A00_0030, 32'h0000_0030},
        {8'h18, 32'h7700_0040, 32'h0000_0040}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mc_hold = 1'b0;
    logic        irq, rst_out, ext_rst_out, rst_push_pull, rst_full_chip;
    int          total = 0;
    int          bad = 0;
    logic        done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    watchdog_top #(.ADDR_W(5), .TICK_DIV(TICK_DIV)) i_watchdog_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mc_hold(mc_hold), .irq(irq), .rst_out(rst_out),
        .ext_rst_out(ext_rst_out), .rst_push_pull(rst_push_pull),
        .rst_full_chip(rst_full_chip)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; consumes exactly one rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); chk("R1 counter", v, 32'h03EF_1480);
        rd(5'h04, v); chk("R1 reload", v, 32'h03EF_1480);
        rd(5'h0C, v); chk("R1 control", v, 32'h0);
        rd(5'h18, v); chk("R1 config", v, 32'h0000_00FF);
        chk("R1 outputs idle", {29'd0, irq, rst_out, ext_rst_out}, 32'h3);

        // R2 R3 R9 register vectors
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rd(VEC[i][68:64], v);
            chk($sformatf("R2 R3 R9 vector %0d", i), v, VEC[i][31:0]);
        end

        // R5 enable rise reloads, raw clock ticks (R6)
        wr(5'h18, 32'h0000_0003);
        wr(5'h04, 32'd10);
        wr(5'h0C, 32'h0000_000F);
        rd(5'h00, v); chk("R5 enable rise loads", v, 32'd10);
        repeat (4) @(negedge clk);
        rd(5'h00, v); chk("R6 raw tick count", v, 32'd6);

        // R4 wrong keys
        wr(5'h08, 32'h0000_4756);
        rd(5'h00, v); chk("R4 wrong key ignored", v, 32'd5);
        wr(5'h08, 32'h4755_0000);
        rd(5'h00, v); chk("R4 key in upper half ignored", v, 32'd4);
        wr(5'h08, 32'hABCD_4755);
        rd(5'h00, v); chk("R4 key restart", v, 32'd10);

        // R5 disable freezes, re-enable reloads
        wr(5'h0C, 32'h0000_000E);
        repeat (5) @(negedge clk);
        rd(5'h00, v); chk("R5 disable freezes", v, 32'd9);
        wr(5'h0C, 32'h0000_000F);
        rd(5'h00, v); chk("R5 re-enable reloads", v, 32'd10);

        // R7 R10 R11 expiry, active-low, width 3
        repeat (9) @(negedge clk);
        rd(5'h00, v); chk("R7 one before expiry", v, 32'd1);
        chk("R10 idle before expiry", {30'd0, rst_out, irq}, 32'h2);
        @(negedge clk);
        chk("R10 pulse asserted low", {30'd0, rst_out, ext_rst_out}, 32'h0);
        chk("R11 irq set", {31'd0, irq}, 32'h1);
        repeat (2) @(negedge clk);
        chk("R10 pulse still asserted", {31'd0, rst_out}, 32'h0);
        @(negedge clk);
        chk("R10 pulse ends after width", {30'd0, rst_out, ext_rst_out}, 32'h3);
        repeat (5) @(negedge clk);
        rd(5'h00, v); chk("R7 halted at zero", v, 32'd0);
        chk("R11 irq sticky", {31'd0, irq}, 32'h1);
        wr(5'h08, 32'h0000_4755);
        chk("R4 restart clears irq", {31'd0, irq}, 32'h0);

        // R9 R10 active-high, external disabled
        wr(5'h18, 32'hA500_0002);
        chk("R9 active-high idle", {30'd0, rst_out, ext_rst_out}, 32'h0);
        wr(5'h0C, 32'h0000_0007);
        rd(5'h00, v); chk("R5 control rewrite no reload", v, 32'd8);
        wr(5'h08, 32'h0000_4755);
        repeat (10) @(negedge clk);
        chk("R10 active-high pulse, no ext", {30'd0, rst_out, ext_rst_out}, 32'h2);
        chk("R11 irq on timeout", {31'd0, irq}, 32'h1);
        repeat (3) @(negedge clk);

        // R12 hold vetoes expiry
        mc_hold = 1'b1;
        wr(5'h08, 32'h0000_4755);
        repeat (10) @(negedge clk);
        rd(5'h0C, v); chk("R12 control wiped", v, 32'h0);
        chk("R12 no pulse no irq", {30'd0, rst_out, irq}, 32'h0);
        rd(5'h00, v); chk("R12 counter zero", v, 32'd0);
        mc_hold = 1'b0;

        // R8 restart on expiry cycle wins
        wr(5'h0C, 32'h0000_0007);
        repeat (9) @(negedge clk);
        wr(5'h08, 32'h0000_4755);
        rd(5'h00, v); chk("R8 restart beats expiry", v, 32'd10);
        chk("R8 no pulse no irq", {30'd0, rst_out, irq}, 32'h0);

        // R6 microsecond tick timing
        wr(5'h0C, 32'h0000_0017);
        wr(5'h08, 32'h0000_4755);
        repeat (TICK_DIV - 1) @(negedge clk);
        rd(5'h00, v); chk("R6 no step before divider", v, 32'd10);
        @(negedge clk);
        rd(5'h00, v); chk("R6 first microsecond step", v, 32'd9);

        // R2 unaligned access, R9 push-pull pin, R3 full-chip pin
        wr(5'h05, 32'h0000_0005);
        rd(5'h04, v); chk("R2 unaligned write ignored", v, 32'd10);
        rd(5'h06, v); chk("R2 unaligned read zero", v, 32'd0);
        wr(5'h18, 32'hA800_0002);
        chk("R9 push-pull pin", {31'd0, rst_push_pull}, 32'h1);
        wr(5'h0C, 32'h0000_0037);
        chk("R3 full-chip pin", {31'd0, rst_full_chip}, 32'h1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule